// File: doc/BRIEF.md
# Boundary-Scan Pin Chain

This block is the chain of boundary-scan cells placed between the core logic and the device pins. It has one observe-only cell per input pin and two cells per output pin: one carries the output value and one carries the output enable. Each output-side cell pairs a capture/shift flip-flop with an update latch. A test access controller outside the block supplies the capture, shift and update strobes and the active-instruction decodes. The block returns the serial output and the values that drive the pins.

The shift stage is a single register of `LEN = NUM_IN + 2*NUM_OUT` bits. Cell 0 sits next to the serial output. Cells `0 .. NUM_IN-1` observe input pins `0 .. NUM_IN-1`. For output pin k, cell `NUM_IN+2k` holds the data and cell `NUM_IN+2k+1` holds the enable. The chain is on the scan path only while the sample/preload decode or the external-test decode is active.

The pin multiplexer works in one of three named modes, chosen from the decodes:
- `MODE_CORE`: no driving decode is active. The core data and enable pass straight through.
- `MODE_LATCH`: the external-test or clamp decode is active. The update latches drive the pins.
- `MODE_FLOAT`: the high-impedance decode is active. This mode takes priority over the other two, and every enable is forced low.

The mode changes directly as the decodes change: CORE to LATCH when external-test or clamp rises, any mode to FLOAT when high-impedance rises, and back to CORE when every decode falls.

Top module: `bsr_chain`

## Requirements
- R1: While `trst_n` is low, the shift stage and every update latch are cleared to 0. Under external-test the pins then read data 0 and enable 0, and `tdo` reads 0.
- R2: With no external-test, clamp or high-impedance decode active, `pin_do` equals `core_do` and `pin_oe` equals `core_oe`.
- R3: On a rising `tck` edge with `capture_dr` high and the chain selected (sample or external-test), the cells load their capture values. Cell i takes `pin_di[i]`, cell NUM_IN+2k takes `core_do[k]`, and cell NUM_IN+2k+1 takes `core_oe[k]`.
- R4: On a rising `tck` edge with `shift_dr` high, the chain selected and no capture, each cell takes the value of its neighbour one position nearer `tdi`. The top cell takes `tdi`, and `tdo` always shows cell 0. A word shifted in bit 0 first is therefore read back bit 0 first after LEN shifts.
- R5: Capture and shift under sample/preload leave `pin_do` and `pin_oe` equal to the core values.
- R6: The update latches load the output-side cells only on a falling `tck` edge with `update_dr` high and the chain selected. Shifting without an update leaves the pins unchanged.
- R7: Data preloaded and updated under sample/preload does not appear on the pins until external-test or clamp becomes active.
- R8: Under external-test or clamp, with high-impedance inactive, pin k is driven with data from latch NUM_IN+2k and enable from latch NUM_IN+2k+1.
- R9: Under high-impedance, every `pin_oe` bit is 0 and `pin_do` follows `core_do`.
- R10: While only clamp or high-impedance is active, the capture, shift and update strobes change neither the shift stage nor the update latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tdi | input | 1 | Serial data into the top cell |
| capture_dr | input | 1 | Capture strobe |
| shift_dr | input | 1 | Shift strobe |
| update_dr | input | 1 | Update strobe (acts on falling tck) |
| ins_sample | input | 1 | Sample/preload decode |
| ins_extest | input | 1 | External-test decode |
| ins_clamp | input | 1 | Clamp decode |
| ins_highz | input | 1 | High-impedance decode |
| pin_di | input | NUM_IN | Values seen on input pins |
| core_do | input | NUM_OUT | Core output data |
| core_oe | input | NUM_OUT | Core output enables |
| pin_do | output | NUM_OUT | Data toward output pins |
| pin_oe | output | NUM_OUT | Enables toward output pins |
| tdo | output | 1 | Serial output, cell 0 |

## Verification
A wrong shift-stage bit stays hidden until it is shifted out. It then appears on `tdo` in the cycle that matches its cell index, so a capture followed by a full-length shift places each error at a known serial position. A wrong update latch shows on `pin_do` or `pin_oe` as soon as external-test or clamp is active, with no clock needed. If a strobe leaks while the chain is deselected, the latches or the shift stage are corrupted. That corruption appears on the next clamp observation of the pins or on the next readout under sample.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    typedef enum logic [1:0] {
        MODE_CORE  = 2'd0,
        MODE_LATCH = 2'd1,
        MODE_FLOAT = 2'd2
    } pin_mode_e;

    // High impedance wins over latch drive, which wins over core pass-through.
    function automatic pin_mode_e pick_mode(input logic ext, input logic clamp,
                                            input logic highz);
        if (highz)
            return MODE_FLOAT;
        else if (ext || clamp)
            return MODE_LATCH;
        else
            return MODE_CORE;
    endfunction

endpackage

// File: rtl/bsr_shift.sv
module bsr_shift #(
    parameter int NUM_IN  = 8,
    parameter int NUM_OUT = 8,
    parameter int LEN     = NUM_IN + 2 * NUM_OUT
) (
    input  logic               tck,
    input  logic               trst_n,
    input  logic               tdi,
    input  logic               cap_en,
    input  logic               shf_en,
    input  logic [NUM_IN-1:0]  pin_di,
    input  logic [NUM_OUT-1:0] core_do,
    input  logic [NUM_OUT-1:0] core_oe,
    output logic [LEN-1:0]     chain_q
);

    logic [LEN-1:0] cap_vec;

    // Input observe cells occupy the low end, next to tdo.
    for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_in_cell
        assign cap_vec[gi] = pin_di[gi];
    end

    // Each output pin owns a data cell followed by an enable cell.
    for (genvar go = 0; go < NUM_OUT; go++) begin : g_out_cell
        assign cap_vec[NUM_IN + 2*go]     = core_do[go];
        assign cap_vec[NUM_IN + 2*go + 1] = core_oe[go];
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)
            chain_q <= '0;
        else if (cap_en)
            chain_q <= cap_vec;
        else if (shf_en)
            chain_q <= {tdi, chain_q[LEN-1:1]};
    end

endmodule

// File: rtl/bsr_update.sv
module bsr_update #(
    parameter int NUM_OUT = 8,
    localparam int UW     = 2 * NUM_OUT
) (
    input  logic               tck,
    input  logic               trst_n,
    input  logic               upd_en,
    input  logic [UW-1:0]      out_cells,
    output logic [NUM_OUT-1:0] lat_do,
    output logic [NUM_OUT-1:0] lat_oe
);

    logic [UW-1:0] upd_q;

    // Update stage loads on the falling test-clock edge.
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n)
            upd_q <= '0;
        else if (upd_en)
            upd_q <= out_cells;
    end

    for (genvar gk = 0; gk < NUM_OUT; gk++) begin : g_split
        assign lat_do[gk] = upd_q[2*gk];
        assign lat_oe[gk] = upd_q[2*gk + 1];
    end

endmodule

// File: rtl/bsr_pinmux.sv
module bsr_pinmux
    import bsr_pkg::*;
#(
    parameter int NUM_OUT = 8
) (
    input  logic               ins_extest,
    input  logic               ins_clamp,
    input  logic               ins_highz,
    input  logic [NUM_OUT-1:0] core_do,
    input  logic [NUM_OUT-1:0] core_oe,
    input  logic [NUM_OUT-1:0] lat_do,
    input  logic [NUM_OUT-1:0] lat_oe,
    output logic [NUM_OUT-1:0] pin_do,
    output logic [NUM_OUT-1:0] pin_oe
);

    pin_mode_e mode;

    always_comb begin
        mode = pick_mode(ins_extest, ins_clamp, ins_highz);
    end

    always_comb begin
        unique case (mode)
            MODE_LATCH: begin
                pin_do = lat_do;
                pin_oe = lat_oe;
            end
            MODE_FLOAT: begin
                pin_do = core_do;
                pin_oe = '0;
            end
            default: begin
                pin_do = core_do;
                pin_oe = core_oe;
            end
        endcase
    end

endmodule

// File: rtl/bsr_chain.sv
module bsr_chain #(
    parameter int NUM_IN  = 8,
    parameter int NUM_OUT = 8
) (
    input  logic               tck,
    input  logic               trst_n,
    input  logic               tdi,
    input  logic               capture_dr,
    input  logic               shift_dr,
    input  logic               update_dr,
    input  logic               ins_sample,
    input  logic               ins_extest,
    input  logic               ins_clamp,
    input  logic               ins_highz,
    input  logic [NUM_IN-1:0]  pin_di,
    input  logic [NUM_OUT-1:0] core_do,
    input  logic [NUM_OUT-1:0] core_oe,
    output logic [NUM_OUT-1:0] pin_do,
    output logic [NUM_OUT-1:0] pin_oe,
    output logic               tdo
);

    localparam int LEN = NUM_IN + 2 * NUM_OUT;

    logic               chain_sel;
    logic [LEN-1:0]     chain_q;
    logic [NUM_OUT-1:0] lat_do;
    logic [NUM_OUT-1:0] lat_oe;

    // The chain sits on the scan path only for sample/preload and external test.
    assign chain_sel = ins_sample | ins_extest;

    bsr_shift #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .LEN(LEN)) u_shift (
        .tck     (tck),
        .trst_n  (trst_n),
        .tdi     (tdi),
        .cap_en  (capture_dr & chain_sel),
        .shf_en  (shift_dr & chain_sel),
        .pin_di  (pin_di),
        .core_do (core_do),
        .core_oe (core_oe),
        .chain_q (chain_q)
    );

    bsr_update #(.NUM_OUT(NUM_OUT)) u_update (
        .tck       (tck),
        .trst_n    (trst_n),
        .upd_en    (update_dr & chain_sel),
        .out_cells (chain_q[LEN-1:NUM_IN]),
        .lat_do    (lat_do),
        .lat_oe    (lat_oe)
    );

    bsr_pinmux #(.NUM_OUT(NUM_OUT)) u_pinmux (
        .ins_extest (ins_extest),
        .ins_clamp  (ins_clamp),
        .ins_highz  (ins_highz),
        .core_do    (core_do),
        .core_oe    (core_oe),
        .lat_do     (lat_do),
        .lat_oe     (lat_oe),
        .pin_do     (pin_do),
        .pin_oe     (pin_oe)
    );

    assign tdo = chain_q[0];

endmodule

// File: rtl/bsr_chain_chk.sv
module bsr_chain_chk #(
    parameter int NUM_IN  = 8,
    parameter int NUM_OUT = 8,
    localparam int LEN    = NUM_IN + 2 * NUM_OUT
) (
    input logic               tck,
    input logic               trst_n,
    input logic               tdi,
    input logic               capture_dr,
    input logic               shift_dr,
    input logic               update_dr,
    input logic               ins_sample,
    input logic               ins_extest,
    input logic               ins_clamp,
    input logic               ins_highz,
    input logic [NUM_IN-1:0]  pin_di,
    input logic [NUM_OUT-1:0] core_do,
    input logic [NUM_OUT-1:0] core_oe,
    input logic [NUM_OUT-1:0] pin_do,
    input logic [NUM_OUT-1:0] pin_oe,
    input logic               tdo,
    input logic [LEN-1:0]     chain_q,
    input logic [NUM_OUT-1:0] lat_do,
    input logic [NUM_OUT-1:0] lat_oe
);

    logic sel;
    assign sel = ins_sample | ins_extest;

    assert_pass_through_R2: assert property (@(posedge tck) disable iff (!trst_n)
        (!ins_extest && !ins_clamp && !ins_highz) |-> (pin_do == core_do && pin_oe == core_oe));

    assert_capture_load_R3: assert property (@(posedge tck) disable iff (!trst_n)
        (capture_dr && sel) |=> (chain_q[NUM_IN-1:0] == $past(pin_di)
                                 && chain_q[NUM_IN] == $past(core_do[0])));

    assert_shift_step_R4: assert property (@(posedge tck) disable iff (!trst_n)
        (shift_dr && !capture_dr && sel) |=> (tdo == $past(chain_q[1])
                                 && chain_q[LEN-1] == $past(tdi)
                                 && chain_q[LEN-2:0] == $past(chain_q[LEN-1:1])));

    assert_latch_hold_R6: assert property (@(negedge tck) disable iff (!trst_n)
        !(update_dr && sel) |=> ($stable(lat_do) && $stable(lat_oe)));

    assert_latch_drive_R8: assert property (@(posedge tck) disable iff (!trst_n)
        ((ins_extest || ins_clamp) && !ins_highz) |-> (pin_do == lat_do && pin_oe == lat_oe));

    assert_float_R9: assert property (@(posedge tck) disable iff (!trst_n)
        ins_highz |-> (pin_oe == '0));

    assert_deselect_hold_R10: assert property (@(posedge tck) disable iff (!trst_n)
        !sel |=> $stable(chain_q));

endmodule

bind bsr_chain bsr_chain_chk #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_chk (
    .tck        (tck),
    .trst_n     (trst_n),
    .tdi        (tdi),
    .capture_dr (capture_dr),
    .shift_dr   (shift_dr),
    .update_dr  (update_dr),
    .ins_sample (ins_sample),
    .ins_extest (ins_extest),
    .ins_clamp  (ins_clamp),
    .ins_highz  (ins_highz),
    .pin_di     (pin_di),
    .core_do    (core_do),
    .core_oe    (core_oe),
    .pin_do     (pin_do),
    .pin_oe     (pin_oe),
    .tdo        (tdo),
    .chain_q    (chain_q),
    .lat_do     (lat_do),
    .lat_oe     (lat_oe)
);

// File: tb/bsr_chain_test.sv
module bsr_chain_test;

    localparam int TCK_PERIOD = 10;
    localparam int NI  = 4;
    localparam int NO  = 4;
    localparam int LEN = NI + 2 * NO;

    logic          tck = 1'b0;
    logic          trst_n, tdi, capture_dr, shift_dr, update_dr;
    logic          ins_sample, ins_extest, ins_clamp, ins_highz;
    logic [NI-1:0] pin_di;
    logic [NO-1:0] core_do, core_oe, pin_do, pin_oe;
    logic          tdo;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    bsr_chain #(.NUM_IN(NI), .NUM_OUT(NO)) uut (
        .tck(tck), .trst_n(trst_n), .tdi(tdi), .capture_dr(capture_dr),
        .shift_dr(shift_dr), .update_dr(update_dr), .ins_sample(ins_sample),
        .ins_extest(ins_extest), .ins_clamp(ins_clamp), .ins_highz(ins_highz),
        .pin_di(pin_di), .core_do(core_do), .core_oe(core_oe),
        .pin_do(pin_do), .pin_oe(pin_oe), .tdo(tdo)
    );

    always #(TCK_PERIOD/2) tck = ~tck;

    // Mode table: {ext, clamp, highz, core_do, core_oe, exp_do, exp_oe}.
    // Update latches hold data 4'b1001, enable 4'b0111 while it is walked.
    localparam logic [18:0] VEC [6] = '{
        {3'b000, 4'b0101, 4'b0011, 4'b0101, 4'b0011},
        {3'b100, 4'b0101, 4'b0011, 4'b1001, 4'b0111},
        {3'b010, 4'b1100, 4'b0000, 4'b1001, 4'b0111},
        {3'b001, 4'b1111, 4'b1111, 4'b1111, 4'b0000},
        {3'b000, 4'b1110, 4'b1000, 4'b1110, 4'b1000},
        {3'b101, 4'b0000, 4'b0000, 4'b0000, 4'b0000}
    };

    function automatic logic [LEN-1:0] pack(input logic [NI-1:0] i,
                                            input logic [NO-1:0] d,
                                            input logic [NO-1:0] e);
        logic [LEN-1:0] v;
        v[NI-1:0] = i;
        for (int k = 0; k < NO; k++) begin
            v[NI + 2*k]     = d[k];
            v[NI + 2*k + 1] = e[k];
        end
        return v;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge tck);
        #1;
    endtask

    task automatic shift_chain(input logic [LEN-1:0] din, output logic [LEN-1:0] dout);
        shift_dr = 1'b1;
        for (int i = 0; i < LEN; i++) begin
            tdi     = din[i];
            dout[i] = tdo;
            cyc();
        end
        shift_dr = 1'b0;
        tdi = 1'b0;
    endtask

    task automatic pulse_update();
        update_dr = 1'b1;
        cyc();
        update_dr = 1'b0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(TCK_PERIOD * 20000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [LEN-1:0] outv;
        logic [LEN-1:0] pre_v;
        logic [LEN-1:0] q_v;
        pre_v = pack(4'b0011, 4'b1001, 4'b0111);
        q_v   = pack(4'b0000, 4'b0110, 4'b1111);

        trst_n = 0; tdi = 0; capture_dr = 0; shift_dr = 0; update_dr = 0;
        ins_sample = 0; ins_extest = 0; ins_clamp = 0; ins_highz = 0;
        pin_di = '0; core_do = 4'b1011; core_oe = 4'b0101;
        #3;
        chk("R1 tdo in reset", 32'(tdo), 32'h0);
        chk("R2 pin_do in reset", 32'(pin_do), 32'hb);
        chk("R2 pin_oe in reset", 32'(pin_oe), 32'h5);
        ins_extest = 1; #1;
        chk("R1 latches clear", 32'({pin_do, pin_oe}), 32'h0);
        ins_extest = 0;
        cyc(); cyc();
        trst_n = 1;
        cyc();

        // R1: chain empty after reset
        ins_sample = 1;
        shift_chain('0, outv);
        chk("R1 chain clear", 32'(outv), 32'h0);

        // R3/R4/R5: capture then read out
        pin_di = 4'b1010; core_do = 4'b0110; core_oe = 4'b1100;
        capture_dr = 1; cyc(); capture_dr = 0;
        chk("R5 pins after capture", 32'({pin_do, pin_oe}), 32'({4'b0110, 4'b1100}));
        shift_chain(pre_v, outv);
        chk("R3 captured word", 32'(outv), 32'(pack(4'b1010, 4'b0110, 4'b1100)));
        chk("R5 pins after shift", 32'({pin_do, pin_oe}), 32'({4'b0110, 4'b1100}));
        shift_chain(pre_v, outv);
        chk("R4 shifted word", 32'(outv), 32'(pre_v));

        // R7: preload update stays off the pins under sample
        pulse_update();
        chk("R7 preload hidden", 32'({pin_do, pin_oe}), 32'({4'b0110, 4'b1100}));
        ins_sample = 0;

        // Mode table walk: R2, R8, R9
        for (int v = 0; v < 6; v++) begin
            {ins_extest, ins_clamp, ins_highz, core_do, core_oe} = VEC[v][18:8];
            #1;
            chk($sformatf("R8/R9/R2 vec%0d do", v), 32'(pin_do), 32'(VEC[v][7:4]));
            chk($sformatf("R8/R9/R2 vec%0d oe", v), 32'(pin_oe), 32'(VEC[v][3:0]));
        end
        ins_extest = 0; ins_clamp = 0; ins_highz = 0;
        core_do = 4'b0001; core_oe = 4'b0010;

        // R6: shift without update leaves the pins unchanged
        ins_sample = 1;
        shift_chain(q_v, outv);
        ins_sample = 0; ins_extest = 1; #1;
        chk("R6 no update no change", 32'({pin_do, pin_oe}), 32'({4'b1001, 4'b0111}));
        pulse_update();
        chk("R6 update under extest", 32'({pin_do, pin_oe}), 32'({4'b0110, 4'b1111}));

        // R10: strobes ignored under clamp and high impedance
        ins_extest = 0; ins_clamp = 1;
        shift_chain('1, outv);
        pulse_update();
        chk("R10 clamp ignores update", 32'({pin_do, pin_oe}), 32'({4'b0110, 4'b1111}));
        ins_clamp = 0; ins_highz = 1; pin_di = 4'b0101;
        capture_dr = 1; cyc(); capture_dr = 0;
        pulse_update();
        chk("R9 float enables", 32'(pin_oe), 32'h0);
        ins_highz = 0; ins_sample = 1;
        shift_chain('0, outv);
        chk("R10 chain kept", 32'(outv), 32'(q_v));
        ins_sample = 0; ins_clamp = 1; #1;
        chk("R10 latches kept", 32'({pin_do, pin_oe}), 32'({4'b0110, 4'b1111}));

        // R1: reset in the middle of clamp clears the latches
        #2; trst_n = 0; #1;
        chk("R1 mid reset latches", 32'({pin_do, pin_oe}), 32'h0);
        ins_clamp = 0; #1;
        chk("R2 after reset", 32'({pin_do, pin_oe}), 32'({4'b0001, 4'b0010}));
        trst_n = 1;
        cyc();
        summary();
    end

endmodule